// File: doc/BRIEF.md
# NAND Block Hamming Parity Accumulator

This block watches a flash data bus. On every strobe it folds the byte, or the 16-bit word, that is on the bus into a running set of even and odd Hamming parities. It only does this when the strobe's chip-select tag matches the programmed one. The parities come in two kinds:

- Column parities are taken over the bit positions inside each byte.
- Row parities are taken over the byte's position within the block.

For a 512-byte block this gives twelve parity pairs, which together form a 24-bit single-error-correcting code. Software reads the code from a 32-bit result word with a fixed interleaved layout.

Software first sets the enable, the watched chip select, the bus width and the block length. It then pulses clear and lets the transfer run. When the programmed number of bytes has been absorbed, a done flag rises. After that the code is frozen until the next clear.

The parities are kept as plain XOR sums and are not inverted. Error location and correction are left to software.

Top module: `ecc_ham_acc`

## Requirements
- R1: After reset, `ecc_code` is 0 and `done` is 0.
- R2: A one-cycle `clr` sets `ecc_code` to 0, clears the byte position and drops `done` from the next cycle onward. A strobe in the same cycle as `clr` is discarded.
- R3: Column parity j (j = 0, 1, 2, named P1, P2, P4) is split into two halves. The odd half is the XOR of every data bit whose bit position k has bit j set. The even half is the XOR of the bits whose k has bit j clear.
- R4: Row parity j (j = 0..8, named P8 up to P2048) is also split in two. The odd half is the XOR of all bits of the bytes whose block position has bit j set. The even half covers the bytes whose position has bit j clear. Positions count from 0 after a clear.
- R5: The result layout is fixed:
  - Bits 7:0 hold P1e, P2e, P4e, P8e .. P128e, with P1e at bit 0.
  - Bits 11:8 hold P256e .. P2048e.
  - Bits 23:16 hold P1o .. P128o.
  - Bits 27:24 hold P256o .. P2048o.
  - All other bits read 0.
- R6: With `cfg_wide` = 0, each strobe adds `bus_data[7:0]` as one byte. With `cfg_wide` = 1, each strobe adds `bus_data[7:0]` at position n and `bus_data[15:8]` at position n+1, then advances the position by two.
- R7: A strobe changes nothing when `cfg_en` is 0 or when `bus_cs` differs from `cfg_cs`.
- R8: With `cfg_half_m1` = S, the block is 2*(S+1) bytes. `done` rises in the cycle after the strobe that completes the block. Later strobes leave `ecc_code` unchanged until the next clear.
- R9: Since the parities are not inverted, a full 512-byte block of 0xFF bytes yields `ecc_code` = 0 in either width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| cfg_en | input | 1 | Accumulation enable |
| cfg_cs | input | CS_W | Chip select whose strobes are accumulated |
| cfg_wide | input | 1 | 1: 16-bit device, 0: 8-bit device |
| cfg_half_m1 | input | SIZE_W | Block length in bytes divided by two, minus one |
| clr | input | 1 | One-cycle clear of parities, position and done |
| bus_stb | input | 1 | Data strobe |
| bus_cs | input | CS_W | Chip-select tag of the strobe |
| bus_data | input | 16 | Data on the bus |
| ecc_code | output | 32 | Packed parity result |
| done | output | 1 | Programmed block length reached |

## Verification
The bench builds the block with its defaults, CS_W = 3 and SIZE_W = 8. This allows a full 512-byte block, so byte positions reach the top row parity P2048. Short 8-byte blocks are also programmed from the same build to exercise early completion and strobes ignored after done. Single-bit data placed at a known position pins down every field of the packed layout in both bus widths.

// File: rtl/ecc_ham_pkg.sv
package ecc_ham_pkg;
  localparam int BYTE_W   = 8;
  localparam int COL_BITS = 3;
  localparam int LANES    = 2;
  localparam int CODE_W   = 32;
  localparam int ODD_BASE = 16;
  localparam int MAX_PAR  = 12;
endpackage

// File: rtl/ecc_byte_lane.sv
module ecc_byte_lane
  import ecc_ham_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int NPAR = COL_BITS + IDX_W
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              vld_i,
  output logic [NPAR-1:0]   even_o,
  output logic [NPAR-1:0]   odd_o
);
  logic row_par;

  always_comb begin
    even_o  = '0;
    odd_o   = '0;
    row_par = ^byte_i;
    for (int j = 0; j < COL_BITS; j++) begin
      for (int k = 0; k < BYTE_W; k++) begin
        if (k[j]) odd_o[j]  = odd_o[j]  ^ byte_i[k];
        else      even_o[j] = even_o[j] ^ byte_i[k];
      end
    end
    for (int j = 0; j < IDX_W; j++) begin
      odd_o[COL_BITS+j]  = row_par & idx_i[j];
      even_o[COL_BITS+j] = row_par & ~idx_i[j];
    end
    if (!vld_i) begin
      even_o = '0;
      odd_o  = '0;
    end
  end
endmodule

// File: rtl/ecc_blk_cnt.sv
module ecc_blk_cnt #(
  parameter int SIZE_W = 8,
  localparam int IDX_W = SIZE_W + 1,
  localparam int CNT_W = SIZE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic              wide,
  input  logic [SIZE_W-1:0] half_m1,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, total, step_sum;
  logic             done_q, done_d;

  always_comb begin
    total    = CNT_W'({half_m1, 1'b0}) + CNT_W'(2);
    step_sum = cnt_q + (wide ? CNT_W'(2) : CNT_W'(1));
    cnt_d    = cnt_q;
    done_d   = done_q;
    if (clr) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (acc) begin
      cnt_d  = step_sum;
      done_d = (step_sum >= total);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr || acc) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign idx_o  = cnt_q[IDX_W-1:0];
  assign done_o = done_q;

  // R8: once complete, position and flag hold until a clear
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr |=> done_q && (cnt_q == $past(cnt_q)));

  // R2: clear empties the position counter and the flag
  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/ecc_ham_acc.sv
module ecc_ham_acc
  import ecc_ham_pkg::*;
#(
  parameter int CS_W   = 3,
  parameter int SIZE_W = 8,
  localparam int IDX_W = SIZE_W + 1,
  localparam int NPAR  = COL_BITS + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic              cfg_wide,
  input  logic [SIZE_W-1:0] cfg_half_m1,
  input  logic              clr,
  input  logic              bus_stb,
  input  logic [CS_W-1:0]   bus_cs,
  input  logic [15:0]       bus_data,
  output logic [31:0]       ecc_code,
  output logic              done
);
  logic rst_meta, rst_q;
  logic acc;
  logic [IDX_W-1:0] idx;
  logic [NPAR-1:0]  even_q, odd_q, even_d, odd_d;
  logic [NPAR-1:0]  lane_even [LANES];
  logic [NPAR-1:0]  lane_odd  [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign acc = cfg_en && bus_stb && (bus_cs == cfg_cs) && !done && !clr;

  ecc_blk_cnt #(.SIZE_W(SIZE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (clr),
    .acc     (acc),
    .wide    (cfg_wide),
    .half_m1 (cfg_half_m1),
    .idx_o   (idx),
    .done_o  (done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ecc_byte_lane #(.IDX_W(IDX_W)) u_lane (
      .byte_i (bus_data[g*BYTE_W +: BYTE_W]),
      .idx_i  (idx + IDX_W'(g)),
      .vld_i  (acc && ((g == 0) || cfg_wide)),
      .even_o (lane_even[g]),
      .odd_o  (lane_odd[g])
    );
  end

  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    if (clr) begin
      even_d = '0;
      odd_d  = '0;
    end else if (acc) begin
      for (int l = 0; l < LANES; l++) begin
        even_d = even_d ^ lane_even[l];
        odd_d  = odd_d  ^ lane_odd[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (clr || acc) begin
      even_q <= even_d;
      odd_q  <= odd_d;
    end
  end

  always_comb begin
    ecc_code = '0;
    ecc_code[NPAR-1:0]          = even_q;
    ecc_code[ODD_BASE +: NPAR]  = odd_q;
  end

  // R7: strobes tagged for another chip select leave the code alone
  a_r7_foreign_cs: assert property (@(posedge clk) disable iff (!rst_q)
    bus_stb && (bus_cs != cfg_cs) && !clr |=> $stable(ecc_code));

  // R8: a completed block is frozen
  a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_q)
    done && !clr |=> $stable(ecc_code) && done);

  // R2: clear wins over any strobe in the same cycle
  a_r2_clear_code: assert property (@(posedge clk) disable iff (!rst_q)
    clr |=> (ecc_code == '0) && !done);

  // R7: disabled block ignores strobes
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_q)
    !cfg_en && !clr |=> $stable(ecc_code));
endmodule

// File: tb/ecc_ham_acc_bench.sv
module ecc_ham_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CS_W = 3;
  localparam int SIZE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic [CS_W-1:0] cfg_cs = '0;
  logic cfg_wide = 1'b0;
  logic [SIZE_W-1:0] cfg_half_m1 = '0;
  logic clr = 1'b0;
  logic bus_stb = 1'b0;
  logic [CS_W-1:0] bus_cs = '0;
  logic [15:0] bus_data = '0;
  logic [31:0] ecc_code;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1 reset";

  bit [11:0] m_even, m_odd;
  int m_cnt;
  bit m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_ham_acc #(.CS_W(CS_W), .SIZE_W(SIZE_W)) u_ecc_ham_acc (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cs(cfg_cs),
    .cfg_wide(cfg_wide), .cfg_half_m1(cfg_half_m1), .clr(clr),
    .bus_stb(bus_stb), .bus_cs(bus_cs), .bus_data(bus_data),
    .ecc_code(ecc_code), .done(done)
  );

  // behavioural reference: toggles parities bit by bit
  always @(posedge clk) begin
    if (!rst_n) begin
      m_even = '0; m_odd = '0; m_cnt = 0; m_done = 0;
    end else if (clr) begin
      m_even = '0; m_odd = '0; m_cnt = 0; m_done = 0;
    end else if (cfg_en && bus_stb && bus_cs == cfg_cs && !m_done) begin
      int nb;
      nb = cfg_wide ? 2 : 1;
      for (int b = 0; b < nb; b++) begin
        int bv, pos;
        bv = (int'(bus_data) >> (8*b)) & 255;
        pos = m_cnt + b;
        for (int k = 0; k < 8; k++) begin
          if ((bv >> k) & 1) begin
            for (int j = 0; j < 3; j++)
              if ((k >> j) & 1) m_odd[j] = ~m_odd[j]; else m_even[j] = ~m_even[j];
            for (int j = 0; j < 9; j++)
              if ((pos >> j) & 1) m_odd[3+j] = ~m_odd[3+j]; else m_even[3+j] = ~m_even[3+j];
          end
        end
      end
      m_cnt = m_cnt + nb;
      if (m_cnt >= 2*(int'(cfg_half_m1)+1)) m_done = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(ecc_code == {4'b0, m_odd, 4'b0, m_even}, phase, ecc_code, {4'b0, m_odd, 4'b0, m_even});
      check(done == m_done, {phase, " done"}, {31'b0, done}, {31'b0, m_done});
    end
  end

  task automatic cyc(input bit stb, input logic [CS_W-1:0] cs, input logic [15:0] d, input bit c);
    @(negedge clk);
    bus_stb = stb; bus_cs = cs; bus_data = d; clr = c;
  endtask

  task automatic idle();
    cyc(0, '0, '0, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ecc_code == 32'h0 && done == 1'b0, "R1 reset state", ecc_code, 32'h0);

    // R3 R4 R5: single set bit at byte 5, 8-bit device, 512 bytes
    phase = "R5 layout 8-bit";
    cfg_en = 1; cfg_cs = 3'd2; cfg_wide = 0; cfg_half_m1 = 8'd255;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 512; i++) cyc(1, 3'd2, (i == 5) ? 16'h0001 : 16'h0000, 0);
    idle();
    check(ecc_code == 32'h0028_0FD7, "R3 R4 R5 single bit code", ecc_code, 32'h0028_0FD7);
    check(done == 1'b1, "R8 done after 512 bytes", {31'b0, done}, 32'h1);

    phase = "R8 strobe after done";
    cyc(1, 3'd2, 16'h00FF, 0);
    idle();
    check(ecc_code == 32'h0028_0FD7, "R8 frozen after done", ecc_code, 32'h0028_0FD7);

    // R6: same pattern through the 16-bit lane
    phase = "R6 wide mode";
    cfg_wide = 1;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 256; i++) cyc(1, 3'd2, (i == 2) ? 16'h0100 : 16'h0000, 0);
    idle();
    check(ecc_code == 32'h0028_0FD7, "R6 wide single bit code", ecc_code, 32'h0028_0FD7);
    check(done == 1'b1, "R6 R8 wide done", {31'b0, done}, 32'h1);

    // R9: erased block gives zero in both widths
    phase = "R9 all ones 8-bit";
    cfg_wide = 0;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 512; i++) cyc(1, 3'd2, 16'h00FF, 0);
    idle();
    check(ecc_code == 32'h0 && done, "R9 all-FF 8-bit", ecc_code, 32'h0);
    phase = "R9 all ones wide";
    cfg_wide = 1;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 256; i++) cyc(1, 3'd2, 16'hFFFF, 0);
    idle();
    check(ecc_code == 32'h0 && done, "R9 all-FF wide", ecc_code, 32'h0);

    // R7: foreign chip selects and disabled strobes mixed in, short block
    phase = "R7 filter";
    cfg_wide = 0; cfg_half_m1 = 8'd3;
    cyc(0, '0, '0, 1);
    cyc(1, 3'd5, 16'h00A5, 0);
    idle();
    check(ecc_code == 32'h0, "R7 foreign cs ignored", ecc_code, 32'h0);
    cfg_en = 0;
    cyc(1, 3'd2, 16'h00A5, 0);
    idle();
    check(ecc_code == 32'h0, "R7 disabled ignored", ecc_code, 32'h0);
    cfg_en = 1;
    for (int i = 0; i < 12; i++) cyc(1, (i % 3 == 1) ? 3'd6 : 3'd2, 16'((i*37 + 11) & 255), 0);
    idle();
    check(done == 1'b1, "R8 short block done", {31'b0, done}, 32'h1);

    // R2: clear together with a strobe
    phase = "R2 clear vs strobe";
    cyc(0, '0, '0, 1);
    cyc(1, 3'd2, 16'h003C, 0);
    cyc(1, 3'd2, 16'h00C3, 1);
    idle();
    check(ecc_code == 32'h0 && !done, "R2 clear wins", ecc_code, 32'h0);

    // R3 R4 R6: varied data, wide and narrow
    phase = "R4 varied wide";
    cfg_wide = 1; cfg_half_m1 = 8'd40;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 50; i++) cyc(1, 3'd2, 16'((i*7919 + 101) & 16'hFFFF), 0);
    idle();
    phase = "R3 varied narrow";
    cfg_wide = 0; cfg_half_m1 = 8'd255;
    cyc(0, '0, '0, 1);
    for (int i = 0; i < 300; i++) cyc(1, 3'd2, 16'((i*53 + 7) & 255), 0);
    idle();
    repeat (2) idle();
    report();
  end
endmodule